// File: doc/BRIEF.md
# Interrupt controller command decoder

This block is the byte-wide register front end of a single eight-line interrupt controller that sits on a bus with one address bit. It turns bus writes into controller state. A start word followed by up to three data words configures the controller. Mode commands pick what a read returns and can arm a poll. A three-bit command field retires or rotates in-service lines. The block holds the mask, the vector base, the rotation offset and the mode flags. It tells the neighbouring priority resolver what to clear through single-cycle pulses.

The block does not resolve priority itself. The resolver gives it two results. The first is the highest-priority in-service line, which a non-specific end-of-interrupt needs. The second is the currently winning requested line, which a poll read needs. The resolver also gives it the live ISR and IRR vectors for readback. A separate edge/level select register is written through its own strobe. Bits that the instance cannot support read as zero.

Top module: `intc_cmd_decoder`

## Requirements
- R1: A write at address 0 with data bit 4 set is a start word. In the following cycle, mask, rotation offset, special-mask and read-select read as zero, and `ext_word` equals data bit 0. `init_phase` reads 1 (0 = normal, 1 = awaiting base, 2 = awaiting word three, 3 = awaiting word four). `irr_clr` pulses the inverse of `lvl_sel`, and `lvl_hist_clr` and `res_update` pulse.
- R2: A start word with bit 0 clear also clears `auto_eoi` and `nested_mode`. With bit 0 set, both keep their values.
- R3: Address-1 writes while `init_phase` is not 0 advance the sequence. In phase 1, data bits 7..3 load `vec_base` and the phase becomes 2. In phase 2, the write changes no register, and the phase becomes 3 if `ext_word` is set, otherwise 0. In phase 3, `nested_mode` takes data bit 4, `auto_eoi` takes data bit 1, and the phase becomes 0.
- R4: An address-1 write in phase 0 loads the whole byte into `mask_q` and pulses `res_update`.
- R5: An address-0 write with bit 4 clear and bit 3 set is a mode command. Bit 2 set arms `poll_armed`. Bit 1 set copies bit 0 into `rsel_isr` (1 = ISR). Bit 6 set copies bit 5 into `spec_mask`. A cleared enable bit leaves its flag unchanged.
- R6: An address-0 write with bits 4 and 3 clear is a command, with its code in bits 7..5. Codes 0 and 4 write bit 7 into `rot_on_aeoi`. Code 2 changes nothing and raises no pulse.
- R7: Code 1 with `isr_top_valid` high pulses `isr_clr` at the `isr_top_line` bit and pulses `res_update`. Code 5 does the same and sets `prio_off` to (`isr_top_line` + 1) mod 8. With `isr_top_valid` low, both codes do nothing.
- R8: Code 3 pulses `isr_clr` at the line in data bits 2..0. Code 6 sets `prio_off` to (bits 2..0 + 1) mod 8. Code 7 does both. Each pulses `res_update`.
- R9: A read while `poll_armed` is set clears `poll_armed`. If `win_valid` is high, `bus_rdata` becomes `win_line` with the upper bits zero, and `isr_clr` and `irr_clr` both pulse that line's bit. Otherwise `bus_rdata` becomes 7 and no clear pulses.
- R10: A read without poll returns, one cycle after the strobe, `isr_in` (if `rsel_isr`) or `irr_in` at address 0, and `mask_q` at address 1.
- R11: A `lvl_wr` strobe loads `lvl_wdata` AND `LVL_MASK` into `lvl_sel`.
- R12: `isr_clr`, `irr_clr`, `lvl_hist_clr` and `res_update` are high only in the single cycle after the strobe that caused them.
- R13: After reset, every register and pulse output reads zero, and the phase is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 1 | Address bit |
| bus_wdata | input | 8 | Write data |
| lvl_wr | input | 1 | Edge/level select write strobe |
| lvl_wdata | input | 8 | Edge/level select write data |
| isr_in | input | 8 | In-service vector from the resolver |
| irr_in | input | 8 | Request vector from the resolver |
| isr_top_valid | input | 1 | Some in-service bit is set |
| isr_top_line | input | 3 | Highest-priority in-service line |
| win_valid | input | 1 | A request currently wins |
| win_line | input | 3 | Winning request line |
| bus_rdata | output | 8 | Registered read data |
| mask_q | output | 8 | Interrupt mask |
| vec_base | output | 5 | Vector base, bits 7..3 of the vector |
| prio_off | output | 3 | Rotation offset |
| rsel_isr | output | 1 | Read select, 1 = ISR |
| poll_armed | output | 1 | Poll pending for next read |
| spec_mask | output | 1 | Special-mask flag |
| auto_eoi | output | 1 | Automatic end-of-interrupt flag |
| rot_on_aeoi | output | 1 | Rotate on automatic end-of-interrupt |
| nested_mode | output | 1 | Fully nested flag |
| ext_word | output | 1 | Fourth configuration word requested |
| init_phase | output | 2 | Configuration sequence phase |
| lvl_sel | output | 8 | Edge/level select, 1 = level |
| isr_clr | output | 8 | One-cycle ISR clear mask |
| irr_clr | output | 8 | One-cycle IRR clear mask |
| lvl_hist_clr | output | 1 | One-cycle clear of previous-level copy |
| res_update | output | 1 | One-cycle resolver re-evaluation request |

## Verification
The checks assume that `bus_wr`, `bus_rd` and `lvl_wr` never overlap in one cycle. They also assume that the resolver inputs are meaningful whenever a command or poll read samples them. The bench raises exactly one strobe per transfer, at the falling edge, and drops it before the next falling edge. It holds `isr_in`, `irr_in`, the top in-service line and the winning line constant around each transfer. It changes them only between transfers.

// File: rtl/intc_cmd_pkg.sv
package intc_cmd_pkg;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = 3;

    typedef enum logic [1:0] {
        PH_RUN   = 2'd0,
        PH_BASE  = 2'd1,
        PH_SKIP  = 2'd2,
        PH_EXTRA = 2'd3
    } phase_t;

    typedef enum logic [2:0] {
        K_NONE,
        K_START,
        K_MODE,
        K_CMD,
        K_DATA
    } wkind_t;

    typedef enum logic [2:0] {
        C_ROT_OFF = 3'd0,
        C_NS_EOI  = 3'd1,
        C_NOP     = 3'd2,
        C_SP_EOI  = 3'd3,
        C_ROT_ON  = 3'd4,
        C_NS_ROT  = 3'd5,
        C_SET_PRI = 3'd6,
        C_SP_ROT  = 3'd7
    } cmd_t;

    typedef struct packed {
        logic              ld_rot;
        logic              rot_val;
        logic [BYTE_W-1:0] clr;
        logic              ld_off;
        logic [IDX_W-1:0]  off;
        logic              upd;
    } cmd_eff_t;

    function automatic logic [BYTE_W-1:0] line_bit(input logic [IDX_W-1:0] n);
        logic [BYTE_W-1:0] r;
        r    = '0;
        r[n] = 1'b1;
        return r;
    endfunction

    function automatic logic [IDX_W-1:0] next_line(input logic [IDX_W-1:0] n);
        return IDX_W'(n + IDX_W'(1));
    endfunction

endpackage

// File: rtl/intc_word_classify.sv
module intc_word_classify
    import intc_cmd_pkg::*;
(
    input  logic   wr_en,
    input  logic   addr,
    input  logic   bit_start,
    input  logic   bit_mode,
    output wkind_t kind
);
    always_comb begin
        kind = K_NONE;
        if (wr_en) begin
            if (addr)           kind = K_DATA;
            else if (bit_start) kind = K_START;
            else if (bit_mode)  kind = K_MODE;
            else                kind = K_CMD;
        end
    end
endmodule

// File: rtl/intc_init_seq.sv
module intc_init_seq
    import intc_cmd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  wkind_t kind,
    input  logic   ext_req,
    output phase_t phase,
    output logic   ext_word,
    output logic   ld_mask,
    output logic   ld_base,
    output logic   ld_extra
);
    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_RUN;
            ext_word <= 1'b0;
        end else if (kind == K_START) begin
            ext_word <= ext_req;
            phase    <= PH_BASE;
        end else if (kind == K_DATA) begin
            case (phase)
                PH_BASE:  phase <= PH_SKIP;
                PH_SKIP:  phase <= ext_word ? PH_EXTRA : PH_RUN;
                PH_EXTRA: phase <= PH_RUN;
                default:  phase <= PH_RUN;
            endcase
        end
    end

    always_comb begin
        ld_mask  = (kind == K_DATA) && (phase == PH_RUN);
        ld_base  = (kind == K_DATA) && (phase == PH_BASE);
        ld_extra = (kind == K_DATA) && (phase == PH_EXTRA);
    end
endmodule

// File: rtl/intc_cmd_exec.sv
module intc_cmd_exec
    import intc_cmd_pkg::*;
(
    input  logic             en,
    input  logic [2:0]       op,
    input  logic [IDX_W-1:0] arg,
    input  logic             top_valid,
    input  logic [IDX_W-1:0] top_line,
    output cmd_eff_t         eff
);
    always_comb begin
        eff = '0;
        if (en) begin
            case (cmd_t'(op))
                C_ROT_OFF, C_ROT_ON: begin
                    eff.ld_rot  = 1'b1;
                    eff.rot_val = op[2];
                end
                C_NS_EOI, C_NS_ROT: begin
                    if (top_valid) begin
                        eff.clr = line_bit(top_line);
                        eff.upd = 1'b1;
                        if (op[2]) begin
                            eff.ld_off = 1'b1;
                            eff.off    = next_line(top_line);
                        end
                    end
                end
                C_SP_EOI: begin
                    eff.clr = line_bit(arg);
                    eff.upd = 1'b1;
                end
                C_SET_PRI: begin
                    eff.ld_off = 1'b1;
                    eff.off    = next_line(arg);
                    eff.upd    = 1'b1;
                end
                C_SP_ROT: begin
                    eff.clr    = line_bit(arg);
                    eff.ld_off = 1'b1;
                    eff.off    = next_line(arg);
                    eff.upd    = 1'b1;
                end
                default: eff = '0;
            endcase
        end
    end
endmodule

// File: rtl/intc_readback.sv
module intc_readback
    import intc_cmd_pkg::*;
(
    input  logic              addr,
    input  logic              sel_isr,
    input  logic              poll,
    input  logic [BYTE_W-1:0] isr_in,
    input  logic [BYTE_W-1:0] irr_in,
    input  logic [BYTE_W-1:0] imr,
    input  logic              win_valid,
    input  logic [IDX_W-1:0]  win_line,
    output logic [BYTE_W-1:0] rd_val,
    output logic [BYTE_W-1:0] poll_clr,
    output logic              poll_hit
);
    localparam int PAD_W = BYTE_W - IDX_W;

    always_comb begin
        poll_clr = '0;
        poll_hit = 1'b0;
        if (poll) begin
            if (win_valid) begin
                rd_val   = {{PAD_W{1'b0}}, win_line};
                poll_clr = line_bit(win_line);
                poll_hit = 1'b1;
            end else begin
                rd_val = BYTE_W'(7);
            end
        end else if (addr) begin
            rd_val = imr;
        end else begin
            rd_val = sel_isr ? isr_in : irr_in;
        end
    end
endmodule

// File: rtl/intc_cmd_decoder.sv
module intc_cmd_decoder
    import intc_cmd_pkg::*;
#(
    parameter logic [7:0] LVL_MASK = 8'hF8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       lvl_wr,
    input  logic [7:0] lvl_wdata,
    input  logic [7:0] isr_in,
    input  logic [7:0] irr_in,
    input  logic       isr_top_valid,
    input  logic [2:0] isr_top_line,
    input  logic       win_valid,
    input  logic [2:0] win_line,
    output logic [7:0] bus_rdata,
    output logic [7:0] mask_q,
    output logic [4:0] vec_base,
    output logic [2:0] prio_off,
    output logic       rsel_isr,
    output logic       poll_armed,
    output logic       spec_mask,
    output logic       auto_eoi,
    output logic       rot_on_aeoi,
    output logic       nested_mode,
    output logic       ext_word,
    output logic [1:0] init_phase,
    output logic [7:0] lvl_sel,
    output logic [7:0] isr_clr,
    output logic [7:0] irr_clr,
    output logic       lvl_hist_clr,
    output logic       res_update
);
    localparam int BASE_W = BYTE_W - IDX_W;

    wkind_t            kind;
    phase_t            phase;
    logic              ld_mask;
    logic              ld_base;
    logic              ld_extra;
    cmd_eff_t          eff;
    logic [BYTE_W-1:0] rd_val;
    logic [BYTE_W-1:0] poll_clr;
    logic              poll_hit;

    intc_word_classify u_classify (
        .wr_en     (bus_wr),
        .addr      (bus_addr),
        .bit_start (bus_wdata[4]),
        .bit_mode  (bus_wdata[3]),
        .kind      (kind)
    );

    intc_init_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .kind     (kind),
        .ext_req  (bus_wdata[0]),
        .phase    (phase),
        .ext_word (ext_word),
        .ld_mask  (ld_mask),
        .ld_base  (ld_base),
        .ld_extra (ld_extra)
    );

    intc_cmd_exec u_exec (
        .en        (kind == K_CMD),
        .op        (bus_wdata[7:5]),
        .arg       (bus_wdata[IDX_W-1:0]),
        .top_valid (isr_top_valid),
        .top_line  (isr_top_line),
        .eff       (eff)
    );

    intc_readback u_rb (
        .addr      (bus_addr),
        .sel_isr   (rsel_isr),
        .poll      (poll_armed),
        .isr_in    (isr_in),
        .irr_in    (irr_in),
        .imr       (mask_q),
        .win_valid (win_valid),
        .win_line  (win_line),
        .rd_val    (rd_val),
        .poll_clr  (poll_clr),
        .poll_hit  (poll_hit)
    );

    assign init_phase = phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_sel <= '0;
        end else if (lvl_wr) begin
            lvl_sel <= lvl_wdata & LVL_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata    <= '0;
            mask_q       <= '0;
            vec_base     <= '0;
            prio_off     <= '0;
            rsel_isr     <= 1'b0;
            poll_armed   <= 1'b0;
            spec_mask    <= 1'b0;
            auto_eoi     <= 1'b0;
            rot_on_aeoi  <= 1'b0;
            nested_mode  <= 1'b0;
            isr_clr      <= '0;
            irr_clr      <= '0;
            lvl_hist_clr <= 1'b0;
            res_update   <= 1'b0;
        end else begin
            isr_clr      <= '0;
            irr_clr      <= '0;
            lvl_hist_clr <= 1'b0;
            res_update   <= 1'b0;

            if (bus_rd) begin
                bus_rdata <= rd_val;
                if (poll_armed) begin
                    poll_armed <= 1'b0;
                    if (poll_hit) begin
                        isr_clr    <= poll_clr;
                        irr_clr    <= poll_clr;
                        res_update <= 1'b1;
                    end
                end
            end

            case (kind)
                K_START: begin
                    mask_q       <= '0;
                    prio_off     <= '0;
                    spec_mask    <= 1'b0;
                    rsel_isr     <= 1'b0;
                    if (!bus_wdata[0]) begin
                        nested_mode <= 1'b0;
                        auto_eoi    <= 1'b0;
                    end
                    irr_clr      <= ~lvl_sel;
                    lvl_hist_clr <= 1'b1;
                    res_update   <= 1'b1;
                end
                K_MODE: begin
                    if (bus_wdata[2]) poll_armed <= 1'b1;
                    if (bus_wdata[1]) rsel_isr   <= bus_wdata[0];
                    if (bus_wdata[6]) spec_mask  <= bus_wdata[5];
                end
                K_CMD: begin
                    if (eff.ld_rot) rot_on_aeoi <= eff.rot_val;
                    if (eff.ld_off) prio_off    <= eff.off;
                    isr_clr    <= eff.clr;
                    res_update <= eff.upd;
                end
                K_DATA: begin
                    if (ld_mask) begin
                        mask_q     <= bus_wdata;
                        res_update <= 1'b1;
                    end
                    if (ld_base)  vec_base <= bus_wdata[BYTE_W-1:IDX_W];
                    if (ld_extra) begin
                        nested_mode <= bus_wdata[4];
                        auto_eoi    <= bus_wdata[1];
                    end
                end
                default: ;
            endcase
        end
    end

    // The base field and the phase must fit the byte split used above.
    initial begin
        if (BASE_W != 5) $error("vector base width must be five bits");
    end
endmodule

// File: rtl/intc_cmd_decoder_chk.sv
module intc_cmd_decoder_chk #(
    parameter logic [7:0] LVL_MASK = 8'hF8
) (
    input logic       clk,
    input logic       rst,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic       bus_addr,
    input logic [7:0] bus_wdata,
    input logic       lvl_wr,
    input logic [7:0] lvl_wdata,
    input logic [7:0] mask_q,
    input logic [4:0] vec_base,
    input logic [2:0] prio_off,
    input logic       rsel_isr,
    input logic       poll_armed,
    input logic       spec_mask,
    input logic       auto_eoi,
    input logic       nested_mode,
    input logic [1:0] init_phase,
    input logic [7:0] lvl_sel,
    input logic [7:0] isr_clr,
    input logic       lvl_hist_clr,
    input logic       res_update
);
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        bus_wr && !bus_addr && bus_wdata[4] |=>
            mask_q == 8'd0 && prio_off == 3'd0 && !spec_mask && !rsel_isr &&
            init_phase == 2'd1 && lvl_hist_clr && res_update); // R1

    AST_SHORT_START: assert property (@(posedge clk) disable iff (rst)
        bus_wr && !bus_addr && bus_wdata[4] && !bus_wdata[0] |=>
            !auto_eoi && !nested_mode); // R2

    AST_BASE_LOAD: assert property (@(posedge clk) disable iff (rst)
        bus_wr && bus_addr && init_phase == 2'd1 |=>
            vec_base == $past(bus_wdata[7:3]) && init_phase == 2'd2); // R3

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
        bus_wr && bus_addr && init_phase == 2'd0 |=>
            mask_q == $past(bus_wdata) && res_update); // R4

    AST_NOP_CODE: assert property (@(posedge clk) disable iff (rst)
        bus_wr && !bus_addr && bus_wdata[4:3] == 2'b00 && bus_wdata[7:5] == 3'd2 |=>
            isr_clr == 8'd0 && !res_update && $stable(prio_off)); // R6

    AST_SPEC_CLEAR: assert property (@(posedge clk) disable iff (rst)
        bus_wr && !bus_addr && bus_wdata[4:3] == 2'b00 && bus_wdata[7:5] == 3'd3 |=>
            isr_clr == (8'd1 << $past(bus_wdata[2:0])) && res_update); // R8

    AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(isr_clr)); // R8

    AST_POLL_ONESHOT: assert property (@(posedge clk) disable iff (rst)
        bus_rd && poll_armed |=> !poll_armed); // R9

    AST_LVL_MASKED: assert property (@(posedge clk) disable iff (rst)
        lvl_wr |=> lvl_sel == ($past(lvl_wdata) & LVL_MASK)); // R11

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_rd) && !(bus_wr && lvl_wr) && !(bus_rd && lvl_wr)); // R12

    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
        !bus_wr && !bus_rd |=> !lvl_hist_clr); // R12
endmodule

bind intc_cmd_decoder intc_cmd_decoder_chk #(.LVL_MASK(LVL_MASK)) u_chk (.*);

// File: tb/intc_cmd_decoder_tb.sv
module intc_cmd_decoder_tb;
    localparam logic [7:0] MASK = 8'hF8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       lvl_wr = 1'b0;
    logic [7:0] lvl_wdata = '0;
    logic [7:0] isr_in = '0, irr_in = '0;
    logic       isr_top_valid = 1'b0;
    logic [2:0] isr_top_line = '0;
    logic       win_valid = 1'b0;
    logic [2:0] win_line = '0;
    logic [7:0] bus_rdata, mask_q, lvl_sel, isr_clr, irr_clr;
    logic [4:0] vec_base;
    logic [2:0] prio_off;
    logic [1:0] init_phase;
    logic       rsel_isr, poll_armed, spec_mask, auto_eoi, rot_on_aeoi;
    logic       nested_mode, ext_word, lvl_hist_clr, res_update;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    intc_cmd_decoder #(.LVL_MASK(MASK)) u_dut (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic lvl(input logic [7:0] d);
        @(negedge clk);
        lvl_wr = 1'b1; lvl_wdata = d;
        @(negedge clk);
        lvl_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R12 watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [2:0] po;
        logic       ep, er, es;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13 reset state
        chk({mask_q, vec_base, prio_off, init_phase, lvl_sel, bus_rdata} == '0 &&
            !poll_armed && !auto_eoi && !nested_mode && !ext_word, "R13", mask_q, 0);
        chk(isr_clr == 0 && irr_clr == 0 && !res_update && !lvl_hist_clr, "R13", isr_clr, 0);

        // R11 edge/level select masking
        for (int v = 0; v < 256; v++) begin
            lvl(8'(v));
            chk(lvl_sel == (8'(v) & MASK), "R11", lvl_sel, 8'(v) & MASK);
        end

        // R4 mask load in normal phase, R12 pulse width
        for (int v = 0; v < 256; v++) begin
            wr(1'b1, 8'(v));
            chk(mask_q == 8'(v) && res_update, "R4", {res_update, mask_q}, {1'b1, 8'(v)});
            @(negedge clk);
            chk(!res_update, "R12", res_update, 0);
        end

        // R5 mode command sweep
        for (int c = 0; c < 32; c++) begin
            ep = poll_armed | c[2];
            er = c[1] ? c[0] : rsel_isr;
            es = c[4] ? c[3] : spec_mask;
            wr(1'b0, {1'b0, c[4], c[3], 2'b01, c[2], c[1], c[0]});
            chk(poll_armed == ep && rsel_isr == er && spec_mask == es, "R5",
                {poll_armed, rsel_isr, spec_mask}, {ep, er, es});
            if (poll_armed) begin
                win_valid = 1'b0;
                rd(1'b0);
                chk(bus_rdata == 8'd7 && !poll_armed && isr_clr == 0 && irr_clr == 0,
                    "R9", bus_rdata, 7);
            end
        end

        // R10 plain reads
        isr_in = 8'hA5; irr_in = 8'h3C;
        wr(1'b0, 8'h0A);
        rd(1'b0);
        chk(bus_rdata == 8'h3C, "R10", bus_rdata, 8'h3C);
        wr(1'b0, 8'h0B);
        rd(1'b0);
        chk(bus_rdata == 8'hA5, "R10", bus_rdata, 8'hA5);
        rd(1'b1);
        chk(bus_rdata == mask_q && mask_q == 8'hFF, "R10", bus_rdata, 8'hFF);

        // R6 rotate flag and no-op code
        wr(1'b0, 8'h80);
        chk(rot_on_aeoi, "R6", rot_on_aeoi, 1);
        wr(1'b0, 8'h00);
        chk(!rot_on_aeoi, "R6", rot_on_aeoi, 0);
        wr(1'b0, 8'hC4);
        po = prio_off;
        for (int n = 0; n < 8; n++) begin
            wr(1'b0, 8'h40 | 8'(n));
            chk(isr_clr == 0 && !res_update && prio_off == po, "R6", prio_off, po);
        end

        // R8 specific clear, set offset, both
        for (int n = 0; n < 8; n++) begin
            po = prio_off;
            wr(1'b0, 8'h60 | 8'(n));
            chk(isr_clr == (8'd1 << n) && res_update && prio_off == po, "R8",
                isr_clr, 8'd1 << n);
            wr(1'b0, 8'hC0 | 8'(n));
            chk(prio_off == 3'(n + 1) && isr_clr == 0 && res_update, "R8", prio_off, 3'(n + 1));
            wr(1'b0, 8'hC0 | 8'(7 - n));
            wr(1'b0, 8'hE0 | 8'(n));
            chk(isr_clr == (8'd1 << n) && prio_off == 3'(n + 1), "R8",
                {prio_off, isr_clr}, {3'(n + 1), 8'd1 << n});
        end

        // R7 non-specific end of interrupt
        for (int n = 0; n < 8; n++) begin
            isr_top_valid = 1'b1; isr_top_line = 3'(n);
            po = prio_off;
            wr(1'b0, 8'h20);
            chk(isr_clr == (8'd1 << n) && res_update && prio_off == po, "R7",
                isr_clr, 8'd1 << n);
            wr(1'b0, 8'hA0);
            chk(isr_clr == (8'd1 << n) && prio_off == 3'(n + 1), "R7",
                {prio_off, isr_clr}, {3'(n + 1), 8'd1 << n});
        end
        isr_top_valid = 1'b0;
        po = prio_off;
        wr(1'b0, 8'h20);
        chk(isr_clr == 0 && !res_update, "R7", isr_clr, 0);
        wr(1'b0, 8'hA0);
        chk(isr_clr == 0 && prio_off == po, "R7", prio_off, po);

        // R9 poll reads
        for (int n = 0; n < 8; n++) begin
            wr(1'b0, 8'h0C);
            chk(poll_armed, "R9", poll_armed, 1);
            win_valid = 1'b1; win_line = 3'(n);
            rd(1'b0);
            chk(bus_rdata == 8'(n) && isr_clr == (8'd1 << n) && irr_clr == (8'd1 << n) &&
                !poll_armed, "R9", {bus_rdata, irr_clr}, {8'(n), 8'd1 << n});
        end
        win_valid = 1'b0;
        wr(1'b0, 8'h0C);
        rd(1'b1);
        chk(bus_rdata == 8'd7 && irr_clr == 0 && !poll_armed, "R9", bus_rdata, 7);

        // R1 / R3 / R2 configuration with fourth word
        wr(1'b0, 8'h6B);
        lvl(8'hA8);
        wr(1'b0, 8'h11);
        chk(mask_q == 0 && prio_off == 0 && !spec_mask && !rsel_isr && ext_word &&
            init_phase == 2'd1, "R1", {mask_q, prio_off}, 0);
        chk(irr_clr == 8'h57 && lvl_hist_clr && res_update, "R1", irr_clr, 8'h57);
        wr(1'b1, 8'h4F);
        chk(vec_base == 5'd9 && init_phase == 2'd2, "R3", vec_base, 9);
        wr(1'b1, 8'hFF);
        chk(init_phase == 2'd3 && vec_base == 5'd9 && mask_q == 0, "R3", init_phase, 3);
        wr(1'b1, 8'h12);
        chk(nested_mode && auto_eoi && init_phase == 2'd0, "R3",
            {nested_mode, auto_eoi, init_phase}, 5'b11000);
        wr(1'b0, 8'h11);
        chk(nested_mode && auto_eoi, "R2", {nested_mode, auto_eoi}, 2'b11);
        wr(1'b1, 8'h08); wr(1'b1, 8'h00); wr(1'b1, 8'h00);
        chk(!nested_mode && !auto_eoi && init_phase == 0, "R3", {nested_mode, auto_eoi}, 0);

        // R2 / R3 short sequence
        wr(1'b1, 8'h0F);
        wr(1'b0, 8'h13);
        wr(1'b1, 8'h12);
        wr(1'b1, 8'h12);
        wr(1'b0, 8'h10);
        chk(!ext_word && !nested_mode && !auto_eoi, "R2", {nested_mode, auto_eoi}, 0);
        wr(1'b1, 8'hF8);
        chk(vec_base == 5'd31, "R3", vec_base, 31);
        wr(1'b1, 8'h55);
        chk(init_phase == 2'd0 && mask_q == 0, "R3", init_phase, 0);
        wr(1'b1, 8'h5A);
        chk(mask_q == 8'h5A && init_phase == 0, "R4", mask_q, 8'h5A);
        @(negedge clk);
        chk(!lvl_hist_clr && irr_clr == 0 && isr_clr == 0, "R12", irr_clr, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule